// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block makes the hazard decisions for an in-order pipeline with five stages: fetch, decode, execute, memory and write-back. Each cycle it reads the source fields of the instruction in decode and the destination fields and flags held in the ID/EX and EX/MEM pipeline registers. From these it decides whether the decode instruction must wait, whether fetch must skip a cycle, and which copy of each ALU operand the execute stage will use. The datapath, the register file and the memories are outside the block. It only drives their control.

The operand selects are worked out one cycle early, while the consumer is still in decode, and are registered. They therefore apply to the instruction that sits in ID/EX in the following cycle. A mode input switches forwarding on or off. With forwarding off, a dependent instruction waits in decode until its producer is in write-back. This relies on a register file that writes in the first half of a cycle and reads in the second half. A build parameter sets whether instruction fetch and data access share one memory port. A branch in decode blocks fetch for one cycle, so that the next instruction reaches decode only after the branch has left execute.

Top module: `hzc_ctrl`

## Requirements
- R1: With `fwd_en`=1, no stall, and a register-writing producer in ID/EX whose nonzero destination equals a used source in decode, that operand's select is 2'b10 (take from EX/MEM) in the next cycle.
- R2: With `fwd_en`=1, no stall, and the only matching writer in EX/MEM, that operand's select is 2'b01 (take from MEM/WB) in the next cycle.
- R3: When both ID/EX and EX/MEM match the same used source, the younger one wins and the select is 2'b10.
- R4: A destination of register 0 never causes a bypass or a stall.
- R5: With `fwd_en`=1, a load in ID/EX whose destination matches a used source in decode raises `stall` for that cycle, and the next-cycle selects are 2'b00.
- R6: With `fwd_en`=0, `stall` is raised whenever a used source matches the destination of a writer in ID/EX or in EX/MEM. Both selects are 2'b00 in every cycle. A load thus costs one stall cycle more than with forwarding on.
- R7: `bubble` equals `stall`. While `stall` is high, `if_inhibit` is low, because the frozen PC already prevents a fetch.
- R8: With a shared memory port, `if_inhibit` is high in every cycle without a stall in which `mem_access` (a load or store in the memory stage) is high.
- R9: `if_inhibit` is high in every cycle without a stall in which `id_branch` is high.
- R10: A synchronous reset returns both selects to 2'b00.
- R11: A source whose used flag is low never causes a bypass or a stall, whatever its field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 = forwarding mode, 0 = wait for write-back |
| id_rs | input | RW | First source register of the decode instruction |
| id_rt | input | RW | Second source register of the decode instruction |
| id_rs_used | input | 1 | First source is read |
| id_rt_used | input | 1 | Second source is read |
| id_branch | input | 1 | Decode instruction is a branch |
| ex_dst | input | RW | Destination held in ID/EX |
| ex_wr | input | 1 | ID/EX instruction writes a register |
| ex_load | input | 1 | ID/EX instruction is a load |
| mem_dst | input | RW | Destination held in EX/MEM |
| mem_wr | input | 1 | EX/MEM instruction writes a register |
| mem_access | input | 1 | EX/MEM instruction is a load or store |
| sel_a | output | 2 | First ALU operand source (00 file, 01 MEM/WB, 10 EX/MEM) |
| sel_b | output | 2 | Second ALU operand source, same encoding |
| stall | output | 1 | Freeze PC and IF/ID |
| bubble | output | 1 | Clear control fields of ID/EX |
| if_inhibit | output | 1 | Skip fetch: hold PC and load a no-op into IF/ID |

## Verification
The bench sweeps every combination of the register fields and flags over a four-register configuration, in both modes. Sources of register 0 and unused sources are among these cases. A design that let register 0 match would stall or bypass from a value that is never written. A design that put the older EX/MEM copy ahead of ID/EX on a double match would feed a stale operand. The sweep also includes a load producer under each mode. Getting it wrong shows up as a missing stall with forwarding on, or a missing second stall with it off. Stall and fetch-inhibit arriving together is covered as well. A design that raised both would throw away the instruction held in IF/ID.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic [1:0] {
    SRC_FILE  = 2'b00,
    SRC_WBREG = 2'b01,
    SRC_MEMRG = 2'b10
  } src_sel_e;
endpackage

// File: rtl/hzc_match.sv
module hzc_match #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic          used,
  input  logic [RW-1:0] dst,
  input  logic          wr,
  output logic          hit
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = used && wr && (dst != ZERO_REG) && (src == dst);
  end
endmodule

// File: rtl/hzc_stall.sv
module hzc_stall #(
  parameter int NSRC        = 2,
  parameter bit SHARED_PORT = 1'b1
) (
  input  logic            fwd_en,
  input  logic            ex_load,
  input  logic [NSRC-1:0] hit_ex,
  input  logic [NSRC-1:0] hit_mem,
  input  logic            id_branch,
  input  logic            mem_access,
  output logic            stall,
  output logic            bubble,
  output logic            if_inhibit
);
  logic port_busy;
  logic any_ex;
  logic any_mem;
  logic data_wait;

  generate
    if (SHARED_PORT) begin : g_shared
      assign port_busy = mem_access;
    end else begin : g_split
      assign port_busy = 1'b0;
    end
  endgenerate

  always_comb begin
    any_ex  = |hit_ex;
    any_mem = |hit_mem;
    if (fwd_en) begin
      data_wait = any_ex && ex_load;
    end else begin
      data_wait = any_ex || any_mem;
    end
    stall      = data_wait;
    bubble     = data_wait;
    if_inhibit = !data_wait && (port_busy || id_branch);
  end
endmodule

// File: rtl/hzc_bypass_reg.sv
module hzc_bypass_reg
  import hzc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fwd_en,
  input  logic       hold,
  input  logic       hit_ex,
  input  logic       hit_mem,
  output logic [1:0] sel
);
  src_sel_e sel_q;
  src_sel_e sel_d;

  always_comb begin
    if (!fwd_en || hold) begin
      sel_d = SRC_FILE;
    end else if (hit_ex) begin
      sel_d = SRC_MEMRG;
    end else if (hit_mem) begin
      sel_d = SRC_WBREG;
    end else begin
      sel_d = SRC_FILE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SRC_FILE;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel = sel_q;
endmodule

// File: rtl/hzc_ctrl.sv
module hzc_ctrl #(
  parameter int RW          = 5,
  parameter bit SHARED_PORT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwd_en,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic          id_rs_used,
  input  logic          id_rt_used,
  input  logic          id_branch,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_access,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          stall,
  output logic          bubble,
  output logic          if_inhibit
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][RW-1:0] src_v;
  logic [NSRC-1:0]         used_v;
  logic [NSRC-1:0]         hit_ex;
  logic [NSRC-1:0]         hit_mem;
  logic [NSRC-1:0][1:0]    sel_v;
  logic                    stall_w;

  assign src_v[0]  = id_rs;
  assign src_v[1]  = id_rt;
  assign used_v[0] = id_rs_used;
  assign used_v[1] = id_rt_used;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      hzc_match #(.RW(RW)) u_m_ex (
        .src (src_v[g]),
        .used(used_v[g]),
        .dst (ex_dst),
        .wr  (ex_wr),
        .hit (hit_ex[g])
      );
      hzc_match #(.RW(RW)) u_m_mem (
        .src (src_v[g]),
        .used(used_v[g]),
        .dst (mem_dst),
        .wr  (mem_wr),
        .hit (hit_mem[g])
      );
      hzc_bypass_reg u_byp (
        .clk    (clk),
        .rst    (rst),
        .fwd_en (fwd_en),
        .hold   (stall_w),
        .hit_ex (hit_ex[g]),
        .hit_mem(hit_mem[g]),
        .sel    (sel_v[g])
      );
    end
  endgenerate

  hzc_stall #(.NSRC(NSRC), .SHARED_PORT(SHARED_PORT)) u_stall (
    .fwd_en    (fwd_en),
    .ex_load   (ex_load),
    .hit_ex    (hit_ex),
    .hit_mem   (hit_mem),
    .id_branch (id_branch),
    .mem_access(mem_access),
    .stall     (stall_w),
    .bubble    (bubble),
    .if_inhibit(if_inhibit)
  );

  assign stall = stall_w;
  assign sel_a = sel_v[0];
  assign sel_b = sel_v[1];
endmodule

// File: rtl/hzc_ctrl_chk.sv
module hzc_ctrl_chk #(
  parameter int RW          = 5,
  parameter bit SHARED_PORT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          fwd_en,
  input logic          id_rs_used,
  input logic          id_rt_used,
  input logic          id_branch,
  input logic [RW-1:0] ex_dst,
  input logic          ex_wr,
  input logic          ex_load,
  input logic [RW-1:0] mem_dst,
  input logic          mem_wr,
  input logic          mem_access,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic          stall,
  input logic          bubble,
  input logic          if_inhibit
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  assert_sel_code_R1: assert property (@(posedge clk) disable iff (rst)
    (sel_a != 2'b11) && (sel_b != 2'b11));

  assert_zero_reg_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    stall |-> ((ex_wr && ex_dst != ZERO_REG) || (!fwd_en && mem_wr && mem_dst != ZERO_REG)));

  assert_load_only_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && stall) |-> ex_load);

  assert_stall_sel_file_R5: assert property (@(posedge clk) disable iff (rst)
    stall |=> (sel_a == 2'b00 && sel_b == 2'b00));

  assert_nofwd_sel_file_R6: assert property (@(posedge clk) disable iff (rst)
    !fwd_en |=> (sel_a == 2'b00 && sel_b == 2'b00));

  assert_bubble_with_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (bubble == stall) && !(stall && if_inhibit));

  assert_branch_holds_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    (!stall && id_branch) |-> if_inhibit);

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (sel_a == 2'b00 && sel_b == 2'b00));

  assert_unused_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!id_rs_used && !id_rt_used) |-> !stall);

  generate
    if (SHARED_PORT) begin : g_port_chk
      assert_port_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (!stall && mem_access) |-> if_inhibit);
    end
  endgenerate
endmodule

bind hzc_ctrl hzc_ctrl_chk #(.RW(RW), .SHARED_PORT(SHARED_PORT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fwd_en    (fwd_en),
  .id_rs_used(id_rs_used),
  .id_rt_used(id_rt_used),
  .id_branch (id_branch),
  .ex_dst    (ex_dst),
  .ex_wr     (ex_wr),
  .ex_load   (ex_load),
  .mem_dst   (mem_dst),
  .mem_wr    (mem_wr),
  .mem_access(mem_access),
  .sel_a     (sel_a),
  .sel_b     (sel_b),
  .stall     (stall),
  .bubble    (bubble),
  .if_inhibit(if_inhibit)
);

// File: tb/hzc_ctrl_bench.sv
`timescale 1ns/1ps
module hzc_ctrl_bench;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fwd_en = 1'b0;
  logic [RW-1:0] id_rs = '0, id_rt = '0, ex_dst = '0, mem_dst = '0;
  logic id_rs_used = 1'b0, id_rt_used = 1'b0, id_branch = 1'b0;
  logic ex_wr = 1'b0, ex_load = 1'b0, mem_wr = 1'b0, mem_access = 1'b0;
  logic [1:0] sel_a, sel_b;
  logic stall, bubble, if_inhibit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hzc_ctrl #(.RW(RW), .SHARED_PORT(1'b1)) u_hzc_ctrl (
    .clk(clk), .rst(rst), .fwd_en(fwd_en),
    .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
    .id_branch(id_branch), .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_access(mem_access),
    .sel_a(sel_a), .sel_b(sel_b), .stall(stall), .bubble(bubble), .if_inhibit(if_inhibit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit mt(input logic [RW-1:0] s, input logic u,
                            input logic [RW-1:0] d, input logic w);
    return u && w && (d != 0) && (s == d);
  endfunction

  // Expected next-cycle select and the requirement it exercises
  function automatic int exp_sel(input logic [RW-1:0] s, input logic u, input bit stl);
    bit he = mt(s, u, ex_dst, ex_wr);
    bit hm = mt(s, u, mem_dst, mem_wr);
    if (!fwd_en || stl) return 0;
    if (he) return 2;
    if (hm) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(input logic [RW-1:0] s, input logic u, input bit stl);
    bit he = mt(s, u, ex_dst, ex_wr);
    bit hm = mt(s, u, mem_dst, mem_wr);
    if (!fwd_en) return "R6 select";
    if (stl) return "R5 select";
    if (!u) return "R11 select";
    if (s == 0) return "R4 select";
    if (he && hm) return "R3 select";
    if (he) return "R1 select";
    if (hm) return "R2 select";
    return "R11 select";
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ea, eb;
    string ta, tb;
    bit valid;
    valid = 1'b0;
    ea = 0; eb = 0; ta = ""; tb = "";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset sel_a", int'(sel_a), 0);
    chk("R10 reset sel_b", int'(sel_b), 0);
    rst = 1'b0;
    for (int i = 0; i < 65536; i++) begin
      bit es, eh;
      @(negedge clk);
      if (valid) begin
        chk(ta, int'(sel_a), ea);
        chk(tb, int'(sel_b), eb);
      end
      id_rs      = i[1:0];
      id_rt      = i[3:2];
      ex_dst     = i[5:4];
      mem_dst    = i[7:6];
      id_rs_used = i[8];
      id_rt_used = i[9];
      ex_wr      = i[10];
      ex_load    = i[10] & i[11];
      mem_wr     = i[12];
      mem_access = i[13];
      id_branch  = i[14];
      fwd_en     = i[15];
      #1;
      begin
        bit dex, dmem;
        dex  = mt(id_rs, id_rs_used, ex_dst, ex_wr) || mt(id_rt, id_rt_used, ex_dst, ex_wr);
        dmem = mt(id_rs, id_rs_used, mem_dst, mem_wr) || mt(id_rt, id_rt_used, mem_dst, mem_wr);
        es = fwd_en ? (dex && ex_load) : (dex || dmem);
      end
      eh = !es && (mem_access || id_branch);
      chk(fwd_en ? "R5 stall" : "R6 stall", int'(stall), int'(es));
      chk("R7 bubble", int'(bubble), int'(es));
      chk(id_branch ? "R9 R7 if_inhibit" : "R8 R7 if_inhibit", int'(if_inhibit), int'(eh));
      ea = exp_sel(id_rs, id_rs_used, es);
      eb = exp_sel(id_rt, id_rt_used, es);
      ta = sel_tag(id_rs, id_rs_used, es);
      tb = sel_tag(id_rt, id_rt_used, es);
      valid = 1'b1;
    end
    @(negedge clk);
    chk(ta, int'(sel_a), ea);
    chk(tb, int'(sel_b), eb);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid-run reset sel_a", int'(sel_a), 0);
    chk("R10 mid-run reset sel_b", int'(sel_b), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule